// File: doc/BRIEF.md
# Oversampling Serial Data Recovery Receiver

This block takes an asynchronous serial line and turns it into bytes. It runs on a local clock that is a fixed multiple of the bit rate. A two-bit select input sets that multiple to 4, 8, 16 or 32 clocks per bit; x16 is the usual setting. The raw line first goes through a two-stage synchroniser. A registered 2-of-3 majority vote over consecutive synchronised samples then cleans it, so that isolated one-clock spikes never reach the framing logic.

A falling edge on the cleaned line starts a frame. The start bit is checked again at its midpoint, and every later bit is sampled half a bit period after its window opens. Any cleaned transition that appears while data or stop bits are arriving reloads the phase counter. The next sample then lands half a period after that transition. This lets the receiver follow a sender whose bit clock runs slightly fast or slow, much like a small digital PLL.

Each received byte appears with a one-cycle strobe and a framing-error flag. Both stay on the outputs until the next byte arrives.

Top module: `serial_oversample_rx`

## Requirements
- R1: `ratio_sel` sets the clocks per bit: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32. It is changed only while the line is idle.
- R2: The line passes through two synchroniser flip-flops and then a 2-of-3 majority vote over three consecutive samples. A deviation that lasts one clock cycle never changes the recovered data or starts a frame, whether the line is idle or inside a bit.
- R3: A frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. The idle line is high. Reception begins on a high-to-low transition of the filtered line.
- R4: The start bit is re-sampled at its midpoint. If the filtered line is high there, the receiver returns to idle and no byte is reported.
- R5: Each bit is sampled half a bit period after the filtered edge that opened its window. The load value is reduced by one to cover the edge-detect register.
- R6: A filtered edge seen while data or stop bits are being received reloads the phase counter, so that the next sample falls half a bit period later. With alternating data, this recovers frames from a sender whose bit period is one clock longer or shorter than nominal at x16, and one clock longer at x8.
- R7: `rx_valid` is a one-cycle pulse, raised once per frame after the stop bit has been sampled. `rx_data` and `rx_ferr` hold their values until the next pulse.
- R8: `rx_ferr` is 1 when the stop bit samples low and 0 when it samples high. The byte is delivered in both cases.
- R9: While reset is held, `rx_valid`, `rx_data` and `rx_ferr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Clocks-per-bit select (4 << ratio_sel) |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| rx_ferr | output | 1 | Stop bit of the last byte sampled low |

## Verification
A phase counter that drifts or reloads wrongly shows up at the ports only at the end of the frame. It appears as a corrupted byte or a framing flag raised against a good stop bit, about ten bit periods after the start edge. A control state that sticks or aborts wrongly shows up as a missing strobe, or an extra one, within one frame time plus the filter latency. A filter that lets single-clock spikes through shows up as wrong bytes when spikes are injected inside data bits.

// File: rtl/osrx_pkg.sv
package osrx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/osrx_line_filter.sv
module osrx_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic filt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;
  logic                   sync_out;
  logic                   vote;

  assign sync_out = sync_q[SYNC_STAGES-1];
  // majority of the newest synchronised sample and the two before it
  assign vote = (sync_out & hist_q[0]) | (sync_out & hist_q[1]) | (hist_q[0] & hist_q[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      filt_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[0], sync_out};
      filt_o <= vote;
    end
  end

  // R2: the filtered line moves only when two of the three voting samples agree
  p_edge_needs_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_o != $past(filt_o)) |->
      ($past(sync_out) == filt_o) &&
      (($past(hist_q[0]) == filt_o) || ($past(hist_q[1]) == filt_o)));
endmodule

// File: rtl/osrx_bit_timer.sv
module osrx_bit_timer #(
  parameter int BASE_OS = 4,
  parameter int SEL_W   = 2,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             load_half,
  input  logic             load_full,
  output logic             tick
);
  localparam int RW = CNT_W + 1;

  logic [RW-1:0]    ratio;
  logic [CNT_W-1:0] full_m1, half_m1;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign ratio   = RW'(BASE_OS) << ratio_sel;
  assign full_m1 = CNT_W'(ratio - RW'(1));
  assign half_m1 = CNT_W'((ratio >> 1) - RW'(1));
  assign tick    = (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (load_half)          cnt_n = half_m1;
    else if (load_full)     cnt_n = full_m1;
    else if (cnt_q != '0)   cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R5: the phase count always stays inside one bit period
  p_count_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < ratio);
endmodule

// File: rtl/serial_oversample_rx.sv
module serial_oversample_rx #(
  parameter int BASE_OS     = 4,
  parameter int SEL_W       = 2,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     ratio_sel,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_ferr
);
  import osrx_pkg::*;

  localparam int MAX_OS = BASE_OS << ((1 << SEL_W) - 1);
  localparam int CNT_W  = $clog2(MAX_OS);
  localparam int BIT_W  = $clog2(DATA_BITS);

  logic                 filt, filt_d_q;
  logic                 fall, any_edge, tick;
  logic                 load_half, load_full;
  rx_state_e            state_q, state_n;
  logic [BIT_W-1:0]     bit_q, bit_n;
  logic [DATA_BITS-1:0] shift_q, shift_n, data_n;
  logic                 valid_n, ferr_n;

  osrx_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk(clk), .rst_n(rst_n), .line_i(rx_line), .filt_o(filt));

  osrx_bit_timer #(.BASE_OS(BASE_OS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
    .load_half(load_half), .load_full(load_full), .tick(tick));

  assign fall     = filt_d_q & ~filt;
  assign any_edge = filt_d_q ^ filt;

  always_comb begin
    state_n   = state_q;
    bit_n     = bit_q;
    shift_n   = shift_q;
    data_n    = rx_data;
    ferr_n    = rx_ferr;
    valid_n   = 1'b0;
    load_half = 1'b0;
    load_full = 1'b0;
    unique case (state_q)
      RX_IDLE: if (fall) begin
        load_half = 1'b1;
        state_n   = RX_START;
      end
      RX_START: if (tick) begin
        if (filt) state_n = RX_IDLE;
        else begin
          load_full = 1'b1;
          bit_n     = '0;
          state_n   = RX_DATA;
        end
      end
      RX_DATA: if (tick) begin
        shift_n   = {filt, shift_q[DATA_BITS-1:1]};
        load_full = 1'b1;
        if (bit_q == BIT_W'(DATA_BITS - 1)) state_n = RX_STOP;
        else                                bit_n   = bit_q + BIT_W'(1);
      end else if (any_edge) begin
        load_half = 1'b1;
      end
      RX_STOP: if (tick) begin
        valid_n = 1'b1;
        data_n  = shift_q;
        ferr_n  = ~filt;
        state_n = RX_IDLE;
      end else if (any_edge) begin
        load_half = 1'b1;
      end
      default: state_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      filt_d_q <= 1'b1;
      bit_q    <= '0;
      shift_q  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      state_q  <= state_n;
      filt_d_q <= filt;
      bit_q    <= bit_n;
      shift_q  <= shift_n;
      rx_data  <= data_n;
      rx_valid <= valid_n;
      rx_ferr  <= ferr_n;
    end
  end

  // R7: strobe lasts exactly one cycle
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R7: strobe only follows the stop-bit sample
  p_valid_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(state_q) == RX_STOP));
  // R7: error flag holds between strobes
  p_ferr_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (rx_ferr == $past(rx_ferr)));
  // R4: a start bit found high at its midpoint returns to idle with no byte
  p_abort_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick && filt) |=> (state_q == RX_IDLE && !rx_valid));
  // R3: a frame begins only after a falling filtered edge
  p_start_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && $past(state_q) == RX_IDLE) |->
      ($past(filt_d_q) && !$past(filt)));
endmodule

// File: tb/serial_oversample_rx_bench.sv
module serial_oversample_rx_bench;
  logic       clk;
  logic       rst_n;
  logic [1:0] ratio_sel;
  logic       rx_line;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ferr;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;

  // fields: [17:16] ratio select, [15:9] sender bit period, [8] stop bit, [7:0] byte
  localparam int NVEC = 11;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd2, 7'd16, 1'b1, 8'hA5},
    {2'd2, 7'd16, 1'b1, 8'h00},
    {2'd2, 7'd16, 1'b1, 8'hFF},
    {2'd0, 7'd4,  1'b1, 8'h3C},
    {2'd1, 7'd8,  1'b1, 8'h81},
    {2'd3, 7'd32, 1'b1, 8'h5A},
    {2'd2, 7'd17, 1'b1, 8'h55},
    {2'd2, 7'd15, 1'b1, 8'hAA},
    {2'd2, 7'd16, 1'b0, 8'hC3},
    {2'd1, 7'd9,  1'b1, 8'h55},
    {2'd0, 7'd4,  1'b1, 8'hE7}
  };

  serial_oversample_rx u_serial_oversample_rx (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .rx_line(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && rx_valid) vcount = vcount + 1;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rx_line = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v, input int period, input bit glitch);
    for (int c = 0; c < period; c++) begin
      rx_line = (glitch && (c % 3 == 2)) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input int period, input logic [7:0] d,
                            input logic stopb, input bit glitch);
    drive_bit(1'b0, period, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], period, glitch);
    drive_bit(stopb, period, 1'b0);
    rx_line = 1'b1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    rst_n     = 1'b0;
    rx_line   = 1'b1;
    ratio_sel = 2'd2;
    repeat (3) @(negedge clk);
    check_eq("R9 valid in reset", rx_valid, 0);
    check_eq("R9 data in reset", rx_data, 0);
    check_eq("R9 ferr in reset", rx_ferr, 0);
    rst_n = 1'b1;
    idle(10);

    for (int i = 0; i < NVEC; i++) begin
      int         period;
      logic [1:0] sel;
      logic       stopb;
      logic [7:0] d;
      sel    = VEC[i][17:16];
      period = int'(VEC[i][15:9]);
      stopb  = VEC[i][8];
      d      = VEC[i][7:0];
      ratio_sel = sel;
      idle(8);
      base = vcount;
      send_frame(period, d, stopb, 1'b0);
      idle(period + 20);
      check_eq("R7 one strobe per frame", vcount - base, 1);
      if (period != (4 << sel)) check_eq("R6 drifting sender byte", rx_data, d);
      else                      check_eq("R1 R3 R5 nominal byte", rx_data, d);
      check_eq("R8 framing flag", rx_ferr, stopb ? 0 : 1);
    end

    // R2: single-cycle spikes on an idle line start nothing
    ratio_sel = 2'd2;
    idle(20);
    base = vcount;
    for (int k = 0; k < 6; k++) begin
      rx_line = 1'b0;
      @(negedge clk);
      idle(4);
    end
    idle(60);
    check_eq("R2 idle spikes ignored", vcount - base, 0);

    // R2: single-cycle spikes inside data bits leave the byte intact
    base = vcount;
    send_frame(16, 8'hFF, 1'b1, 1'b1);
    idle(40);
    check_eq("R2 spiked ones strobe", vcount - base, 1);
    check_eq("R2 spiked ones byte", rx_data, 8'hFF);
    base = vcount;
    send_frame(16, 8'h00, 1'b1, 1'b1);
    idle(40);
    check_eq("R2 spiked zeros strobe", vcount - base, 1);
    check_eq("R2 spiked zeros byte", rx_data, 8'h00);
    check_eq("R2 spiked zeros flag", rx_ferr, 0);

    // R4: short low pulse at x16 is a false start
    base = vcount;
    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    idle(200);
    check_eq("R4 false start x16", vcount - base, 0);
    // R4: short low pulse at x32 is a false start
    ratio_sel = 2'd3;
    idle(4);
    base = vcount;
    rx_line = 1'b0;
    repeat (10) @(negedge clk);
    idle(400);
    check_eq("R4 false start x32", vcount - base, 0);
    // receiver is back in idle and takes a real frame
    base = vcount;
    send_frame(32, 8'h96, 1'b1, 1'b0);
    idle(60);
    check_eq("R4 frame after abort strobe", vcount - base, 1);
    check_eq("R4 frame after abort byte", rx_data, 8'h96);

    // R7 R8: a bad stop bit still delivers the byte, and both outputs hold
    ratio_sel = 2'd2;
    idle(8);
    base = vcount;
    send_frame(16, 8'h3C, 1'b0, 1'b0);
    idle(150);
    check_eq("R8 byte kept with error", rx_data, 8'h3C);
    check_eq("R7 error flag held", rx_ferr, 1);
    check_eq("R7 single strobe", vcount - base, 1);

    summary();
  end
endmodule